// File: doc/BRIEF.md
# UART Transmit Framer

This block turns parallel characters into an asynchronous serial frame on one output line. A character is offered with a valid/ready handshake. While the line is idle the framer takes the character, the framing settings and the ninth bit together, and then sends a low start bit, the data bits least-significant first, an optional parity bit and a high stop period. The line-control word on the `line_ctl` input holds the framing settings: character length, stop length, parity mode and a break bit. A separate input selects a nine-bit mode. In that mode the length and parity settings have no effect and the ninth data bit takes the place of parity.

Bit timing comes from an oversampling strobe, `os_tick`, that pulses `OS_RATE` times per bit period. Whole bits last `OS_RATE` strobes. This lets the stop period be one and a half bits long for the shortest character. The break bit overrides the line for as long as it is set. The character underneath keeps its timing, so the framer comes out of break with its sequencing intact. An empty flag tells the producer that nothing is pending and the shifter is idle.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ser_out` is 1 and `tx_ready` is 1. `tx_empty` is 1 exactly when no frame is in progress and `tx_valid` is 0.
- R2: An accepted frame starts with one low start bit, followed by the data bits least-significant first. Each start, data and parity bit lasts exactly `OS_RATE` strobes of `os_tick`. The first strobe is counted from the cycle after acceptance.
- R3: `line_ctl[1:0]` selects the number of data bits: 00 gives DATA_W-3, 01 gives DATA_W-2, 10 gives DATA_W-1 and 11 gives DATA_W (5, 6, 7 and 8 by default).
- R4: When `line_ctl[3]` is 0, no parity bit is sent, whatever `line_ctl[5:4]` holds. Code 001 in `line_ctl[5:3]` sends odd parity over the sent data bits. Code 011 sends even parity.
- R5: Code 101 in `line_ctl[5:3]` sends a parity bit of constant 1. Code 111 sends a parity bit of constant 0.
- R6: The stop period is high. With `line_ctl[2]`=0 it lasts `OS_RATE` strobes. With `line_ctl[2]`=1 it lasts 1.5*`OS_RATE` strobes when the length code is 00 in normal mode, and 2*`OS_RATE` strobes otherwise.
- R7: While `line_ctl[6]` is 1, `ser_out` is 0, in the same cycle. The frame in progress keeps its timing and resumes on the line when the bit clears.
- R8: With `nine_mode`=1 at acceptance, nine data bits are sent, with `tx_bit9` as the last one. No parity bit is sent, and `line_ctl[1:0]` and `line_ctl[5:3]` have no effect.
- R9: A character is accepted only in a cycle where `tx_ready` is 1. `tx_ready` stays 0 from acceptance until the stop period completes. `tx_valid`, data and framing changes during a frame do not alter that frame.
- R10: Cycles without an `os_tick` strobe do not advance the frame. The line holds its current bit until strobes resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_W | Character to send |
| tx_bit9 | input | 1 | Ninth data bit, used in nine-bit mode |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Framer idle and able to take a character |
| os_tick | input | 1 | Oversampling strobe, OS_RATE per bit |
| line_ctl | input | 7 | Length [1:0], long stop [2], parity [5:3], break [6] |
| nine_mode | input | 1 | Nine-bit framing select |
| ser_out | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Nothing pending and shifter idle |

## Verification
A fault in the strobe counter or phase register shows on `ser_out` within one bit period. The wrong level appears at the first bit boundary that falls in the wrong cycle, and `tx_ready` rises early or late at the end of the stop period. A wrong latched bit count, parity value or shifted datum shows as a wrong level during that bit of the same frame. A fault in config latching shows only when the control word changes mid-frame, so that case is driven on purpose.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_DATA  = 3'd2,
      PH_PAR   = 3'd3,
      PH_STOP  = 3'd4
   } tx_phase_t;

   typedef struct packed {
      logic       brk;
      logic [2:0] par;
      logic       stop_long;
      logic [1:0] len;
   } line_cfg_t;

   localparam int CTL_W = 7;

endpackage

// File: rtl/utx_frame_plan.sv
module utx_frame_plan
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OS_RATE    = 16,
   parameter bit NINE_SUPPORT = 1'b1,
   localparam int NB_W      = $clog2(DATA_W + 2),
   localparam int TW        = $clog2(2 * OS_RATE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_cfg_t         cfg,
   input  logic              nine_req,
   input  logic [DATA_W-1:0] data,
   input  logic              bit9,
   output logic [NB_W-1:0]   nbits,
   output logic              par_en,
   output logic              par_val,
   output logic [TW-1:0]     stop_ticks,
   output logic [DATA_W:0]   word
);

   logic              nine;
   logic [DATA_W-1:0] mask;
   logic              ones_odd;

   generate
      if (NINE_SUPPORT) begin : g_nine
         assign nine = nine_req;
      end else begin : g_no_nine
         assign nine = 1'b0;
      end
   endgenerate

   assign mask     = {DATA_W{1'b1}} >> (2'd3 - cfg.len);
   assign ones_odd = ^(data & mask);
   assign word     = {nine & bit9, nine ? data : (data & mask)};

   always_comb begin
      if (nine) nbits = NB_W'(DATA_W + 1);
      else      nbits = NB_W'(DATA_W - 3) + NB_W'(cfg.len);
   end

   always_comb begin
      par_en  = cfg.par[0] & ~nine;
      par_val = 1'b0;
      if (cfg.par[2]) par_val = ~cfg.par[1];
      else            par_val = cfg.par[1] ? ones_odd : ~ones_odd;
   end

   always_comb begin
      if (!cfg.stop_long)                 stop_ticks = TW'(OS_RATE);
      else if (!nine && cfg.len == 2'b00) stop_ticks = TW'(OS_RATE + OS_RATE / 2);
      else                                stop_ticks = TW'(2 * OS_RATE);
   end

   AST_NINE_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      nine |-> !par_en && nbits == NB_W'(DATA_W + 1));  // R8
   AST_STOP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ticks == TW'(OS_RATE) || stop_ticks == TW'(OS_RATE + OS_RATE / 2)
      || stop_ticks == TW'(2 * OS_RATE));  // R6
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      nbits >= NB_W'(DATA_W - 3) && nbits <= NB_W'(DATA_W + 1));  // R3

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
   parameter int OS_RATE = 16,
   localparam int TW     = $clog2(2 * OS_RATE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          os_tick,
   input  logic [TW-1:0] phase_len,
   output logic          phase_done
);

   logic [TW-1:0] cnt;

   assign phase_done = run && os_tick && (cnt == phase_len - TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || phase_done) cnt <= '0;
      else if (os_tick)           cnt <= cnt + TW'(1);
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < phase_len);  // R2
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      run && !os_tick |=> cnt == $past(cnt) || !$past(run));  // R10

endmodule

// File: rtl/utx_sequencer.sv
module utx_sequencer
   import uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OS_RATE = 16,
   localparam int NB_W   = $clog2(DATA_W + 2),
   localparam int TW     = $clog2(2 * OS_RATE + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [DATA_W:0] req_word,
   input  logic [NB_W-1:0] req_nbits,
   input  logic            req_par_en,
   input  logic            req_par_val,
   input  logic [TW-1:0]   req_stop,
   input  logic            phase_done,
   output logic            run,
   output logic [TW-1:0]   phase_len,
   output logic            accept,
   output logic            idle,
   output logic            line_raw
);

   tx_phase_t       ph;
   logic [DATA_W:0] sr;
   logic [NB_W-1:0] idx;
   logic [NB_W-1:0] nb;
   logic            pe;
   logic            pv;
   logic [TW-1:0]   st;

   assign idle      = (ph == PH_IDLE);
   assign accept    = idle && req_valid;
   assign run       = !idle;
   assign phase_len = (ph == PH_STOP) ? st : TW'(OS_RATE);

   always_comb begin
      unique case (ph)
         PH_START: line_raw = 1'b0;
         PH_DATA:  line_raw = sr[0];
         PH_PAR:   line_raw = pv;
         default:  line_raw = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         sr  <= '0;
         idx <= '0;
         nb  <= '0;
         pe  <= 1'b0;
         pv  <= 1'b0;
         st  <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (req_valid) begin
               ph  <= PH_START;
               sr  <= req_word;
               idx <= '0;
               nb  <= req_nbits;
               pe  <= req_par_en;
               pv  <= req_par_val;
               st  <= req_stop;
            end
            PH_START: if (phase_done) ph <= PH_DATA;
            PH_DATA: if (phase_done) begin
               sr <= sr >> 1;
               if (idx == nb - NB_W'(1)) ph <= pe ? PH_PAR : PH_STOP;
               else                      idx <= idx + NB_W'(1);
            end
            PH_PAR:  if (phase_done) ph <= PH_STOP;
            PH_STOP: if (phase_done) ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ph == PH_START && !idle);  // R9
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      run && !phase_done |=> $stable(ph) && $stable(sr) && $stable(st));  // R10
   AST_DATA_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      ph == PH_DATA |-> idx < nb);  // R3
   AST_NO_PAR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      ph == PH_PAR |-> pe);  // R4

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int OS_RATE      = 16,
   parameter bit NINE_SUPPORT = 1'b1,
   localparam int NB_W        = $clog2(DATA_W + 2),
   localparam int TW          = $clog2(2 * OS_RATE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_bit9,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              os_tick,
   input  logic [CTL_W-1:0]  line_ctl,
   input  logic              nine_mode,
   output logic              ser_out,
   output logic              tx_empty
);

   generate
      if (DATA_W < 5)                    begin : g_bad_w   $error("DATA_W below 5"); end
      if (OS_RATE < 2 || OS_RATE % 2 != 0) begin : g_bad_os $error("OS_RATE must be even and at least 2"); end
   endgenerate

   line_cfg_t       cfg;
   logic [NB_W-1:0] p_nbits;
   logic            p_par_en;
   logic            p_par_val;
   logic [TW-1:0]   p_stop;
   logic [DATA_W:0] p_word;
   logic            run;
   logic [TW-1:0]   phase_len;
   logic            phase_done;
   logic            accept;
   logic            idle;
   logic            line_raw;

   assign cfg = line_cfg_t'(line_ctl);

   utx_frame_plan #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .NINE_SUPPORT(NINE_SUPPORT)) u_plan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .nine_req(nine_mode), .data(tx_data),
      .bit9(tx_bit9), .nbits(p_nbits), .par_en(p_par_en), .par_val(p_par_val),
      .stop_ticks(p_stop), .word(p_word)
   );

   utx_bit_timer #(.OS_RATE(OS_RATE)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .os_tick(os_tick),
      .phase_len(phase_len), .phase_done(phase_done)
   );

   utx_sequencer #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(tx_valid), .req_word(p_word),
      .req_nbits(p_nbits), .req_par_en(p_par_en), .req_par_val(p_par_val),
      .req_stop(p_stop), .phase_done(phase_done), .run(run), .phase_len(phase_len),
      .accept(accept), .idle(idle), .line_raw(line_raw)
   );

   assign tx_ready = idle;
   assign tx_empty = idle && !tx_valid;
   assign ser_out  = line_raw && !cfg.brk;

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      idle && !cfg.brk |-> line_raw);  // R1
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle) |-> $past(phase_done) && $past(line_raw));  // R6
   AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !tx_ready);  // R9

endmodule

// File: tb/sim_uart_tx_framer.sv
`timescale 1ns/1ps
module sim_uart_tx_framer;

   localparam int DW = 8;
   localparam int OS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          tx_bit9 = 1'b0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic          os_tick = 1'b0;
   logic [6:0]    line_ctl = 7'b0000011;
   logic          nine_mode = 1'b0;
   logic          ser_out;
   logic          tx_empty;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R2";

   int  tick_period = 1;
   int  tdiv = 0;
   bit  tick_pause = 0;

   int  lvl_q[$];
   int  dur_q[$];
   bit  mbusy = 0;
   int  mcnt = 0;

   uart_tx_framer #(.DATA_W(DW), .OS_RATE(OS)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_bit9(tx_bit9),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .os_tick(os_tick),
      .line_ctl(line_ctl), .nine_mode(nine_mode), .ser_out(ser_out), .tx_empty(tx_empty)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      #1;
      if (tick_pause) begin
         os_tick = 1'b0;
      end else if (tdiv >= tick_period - 1) begin
         tdiv = 0;
         os_tick = 1'b1;
      end else begin
         tdiv++;
         os_tick = 1'b0;
      end
   end

   task automatic build_frame();
      int n;
      int ones;
      bit nine;
      nine = nine_mode;
      n = nine ? DW + 1 : DW - 3 + int'(line_ctl[1:0]);
      lvl_q.delete();
      dur_q.delete();
      lvl_q.push_back(0); dur_q.push_back(OS);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         int b;
         b = (i == DW) ? int'(tx_bit9) : int'(tx_data[i]);
         ones += b;
         lvl_q.push_back(b); dur_q.push_back(OS);
      end
      if (!nine && line_ctl[3]) begin
         int p;
         if (line_ctl[5])      p = line_ctl[4] ? 0 : 1;
         else if (line_ctl[4]) p = ones % 2;
         else                  p = 1 - (ones % 2);
         lvl_q.push_back(p); dur_q.push_back(OS);
      end
      lvl_q.push_back(1);
      if (!line_ctl[2])                         dur_q.push_back(OS);
      else if (!nine && line_ctl[1:0] == 2'b00) dur_q.push_back(OS + OS / 2);
      else                                      dur_q.push_back(2 * OS);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mbusy = 0;
         mcnt = 0;
      end else if (!mbusy) begin
         if (tx_valid) begin
            build_frame();
            mbusy = 1;
            mcnt = 0;
         end
      end else if (os_tick) begin
         mcnt++;
         if (mcnt == dur_q[0]) begin
            void'(lvl_q.pop_front());
            void'(dur_q.pop_front());
            mcnt = 0;
            if (lvl_q.size() == 0) mbusy = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         int exp_line;
         exp_line = line_ctl[6] ? 0 : (mbusy ? lvl_q[0] : 1);
         check(ser_out == exp_line[0], line_ctl[6] ? "R7" : cur_req, "ser_out", int'(ser_out), exp_line);
         check(tx_ready == !mbusy, "R9", "tx_ready", int'(tx_ready), int'(!mbusy));
         check(tx_empty == (!mbusy && !tx_valid), "R1", "tx_empty", int'(tx_empty), int'(!mbusy && !tx_valid));
      end
   end

   task automatic wait_idle();
      while (mbusy) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic offer(input logic [DW-1:0] d, input logic b9, input logic [6:0] ctl, input logic nine);
      wait_idle();
      line_ctl = ctl; nine_mode = nine; tx_data = d; tx_bit9 = b9;
      tx_valid = 1'b1;
      @(posedge clk); #2;
      tx_valid = 1'b0;
   endtask

   task automatic send(input string req, input logic [DW-1:0] d, input logic b9, input logic [6:0] ctl, input logic nine);
      cur_req = req;
      offer(d, b9, ctl, nine);
      wait_idle();
      repeat (3) @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
   end

   initial begin
      while (cycles < 150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_out == 1'b1, "R1", "reset ser_out", int'(ser_out), 1);
      check(tx_ready == 1'b1, "R1", "reset tx_ready", int'(tx_ready), 1);
      check(tx_empty == 1'b1, "R1", "reset tx_empty", int'(tx_empty), 1);
      @(posedge clk); #2;

      // R2 / R3: 8-bit, no parity, one stop, strobe every cycle
      send("R2", 8'hA5, 1'b0, 7'b0000011, 1'b0);
      send("R2", 8'h01, 1'b0, 7'b0000011, 1'b0);
      tick_period = 3;
      // R3: shorter lengths, bits above the length must not appear
      send("R3", 8'hFF, 1'b0, 7'b0000000, 1'b0);
      send("R3", 8'hEA, 1'b0, 7'b0000001, 1'b0);
      send("R3", 8'h5B, 1'b0, 7'b0000010, 1'b0);
      // R4: odd, even, and parity disabled with other bits set
      send("R4", 8'h07, 1'b0, 7'b0001011, 1'b0);
      send("R4", 8'h07, 1'b0, 7'b0011011, 1'b0);
      send("R4", 8'h3C, 1'b0, 7'b0001001, 1'b0);
      send("R4", 8'h96, 1'b0, 7'b0110011, 1'b0);
      // R5: forced parity
      send("R5", 8'h00, 1'b0, 7'b0101011, 1'b0);
      send("R5", 8'hFF, 1'b0, 7'b0111011, 1'b0);
      // R6: stop lengths
      send("R6", 8'h15, 1'b0, 7'b0000100, 1'b0);
      send("R6", 8'h2A, 1'b0, 7'b0000101, 1'b0);
      send("R6", 8'hC3, 1'b0, 7'b0000111, 1'b0);
      // R8: nine-bit mode, length and parity codes ignored
      send("R8", 8'h81, 1'b1, 7'b0011000, 1'b1);
      send("R8", 8'h7E, 1'b0, 7'b0101101, 1'b1);
      send("R8", 8'hFF, 1'b1, 7'b0001000, 1'b1);

      // R9: valid and config changes during a frame are ignored
      cur_req = "R9";
      offer(8'h6D, 1'b0, 7'b0001011, 1'b0);
      repeat (20) @(posedge clk);
      #2;
      tx_data = 8'h12; line_ctl = 7'b0000100; tx_valid = 1'b1;
      repeat (5) @(posedge clk);
      #2;
      tx_valid = 1'b0;
      wait_idle();
      repeat (3) @(posedge clk);
      #2;

      // R7: break during a frame and at idle
      cur_req = "R7";
      offer(8'h55, 1'b0, 7'b0000011, 1'b0);
      repeat (40) @(posedge clk);
      #2;
      line_ctl[6] = 1'b1;
      repeat (60) @(posedge clk);
      #2;
      line_ctl[6] = 1'b0;
      wait_idle();
      line_ctl[6] = 1'b1;
      repeat (10) @(posedge clk);
      #2;
      line_ctl[6] = 1'b0;
      repeat (3) @(posedge clk);
      #2;

      // R10: strobes paused mid-frame
      cur_req = "R10";
      offer(8'hB4, 1'b0, 7'b0011011, 1'b0);
      repeat (50) @(posedge clk);
      #2;
      tick_pause = 1;
      repeat (45) @(posedge clk);
      #2;
      tick_pause = 0;
      wait_idle();
      repeat (5) @(posedge clk);
      #2;
      check(tx_ready && ser_out, "R1", "idle after run", int'(tx_ready && ser_out), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule